// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives stereo serial audio as a slave. Several data lines share one bit clock and one frame clock, all driven from outside. The block oversamples these inputs with its own system clock. On each rising edge of the bit clock it takes one bit from every line. It then rebuilds a left and a right signed word per line. Once both halves of a frame have arrived, it presents them together with a one-cycle strobe.

A three-bit format code picks the framing. The code sets three things at once:

- the justification (right-justified, left-justified or I2S);
- the word length in the right-justified cases;
- the range of bit-clock counts allowed per half frame.

The code is sampled while reset is held and is frozen when reset is released. The block counts the bit clocks in every half frame. A count outside the allowed range for the chosen format sets a sticky error flag. A reserved code is flagged and keeps the strobe silent.

Top module: `serial_audio_rx`

## Requirements
- R1: Every data line is sampled on the rising edge of the bit clock, most significant bit first. Words are two's complement and are passed through unchanged apart from alignment.
- R2: Format code 2 (left-justified): the MSB is on the first bit clock after a frame-clock edge. The left channel is sent while the frame clock is high. Up to 24 bits are taken, and bits after the 24th are ignored.
- R3: Format code 3 (I2S): the MSB follows the frame-clock edge by one bit clock, and the left channel is sent while the frame clock is low. A half frame of 16 clocks yields a 16-bit word.
- R4: Format codes 0, 1 and 4 (right-justified) carry 16, 20 and 24-bit words. The LSB is on the last bit clock of each half frame, and all earlier bits of that half are ignored.
- R5: After each completed frame, `frame_valid` pulses high for exactly one system clock, and never on two consecutive cycles. Each pulse comes one cycle after a bit-clock rise. The first pulse follows the first left half and right half that were both observed from their start. A stream of F whole frames followed by two more bit clocks gives F-1 pulses.
- R6: All lines use the same format, and each line's words come out in their own lane of `left_out`/`right_out`. Lane k occupies bits [24k+23:24k].
- R7: The format code is taken while `rst_n` is low and held after release. Later changes of `fmt_sel` have no effect.
- R8: Codes 5, 6 and 7 are reserved. They raise `fmt_err` and `frame_valid` never pulses.
- R9: The allowed bit clocks per half frame are:
  - code 0: 16 to 32;
  - code 1: 20 to 32;
  - codes 2 and 4: 24 to 32;
  - code 3: 16 to 32.
  
  A fully observed half frame outside its range sets `frame_err`, which stays set until reset.
- R10: Reset (`rst_n` low, asynchronous) clears all words, `frame_valid`, `fmt_err` and `frame_err`.
- R11: Words shorter than 24 bits are placed at the top of the 24-bit output and the low bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset; format is sampled while low |
| fmt_sel | input | 3 | Format code (see R2 to R4, R8) |
| bclk_in | input | 1 | Serial bit clock |
| fclk_in | input | 1 | Frame (left/right) clock |
| sdata_in | input | LANES | Serial data lines |
| left_out | output | LANES*WORD_W | Left words, one lane per data line |
| right_out | output | LANES*WORD_W | Right words, one lane per data line |
| frame_valid | output | 1 | One-cycle strobe when a frame of words is ready |
| fmt_err | output | 1 | Latched format code is reserved |
| frame_err | output | 1 | Sticky half-frame length error |

## Verification
The bench builds the block with its defaults: three lines, 24-bit words, a two-stage input synchronizer and a 7-bit half-frame counter. The 7-bit counter makes the 33-clock over-range case reachable without saturation. The bit clock runs at one eighth of the system clock, so every frame-clock edge and bit are well clear of the synchronizer.

Each format is driven at its shortest and its widest legal half frame. The right-justified cases include padding bits that must be ignored, and the 16-clock I2S case checks the word that straddles the frame-clock edge. Further runs cover a reserved code, a format change after reset release, and an error that must stay set through later good frames.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam int unsigned SAR_MAX_BITS = 24;
   localparam int unsigned SAR_MAX_HALF = 32;

   typedef enum logic [2:0] {
      FMT_RJ16 = 3'd0,
      FMT_RJ20 = 3'd1,
      FMT_LJ   = 3'd2,
      FMT_I2S  = 3'd3,
      FMT_RJ24 = 3'd4,
      FMT_RSV5 = 3'd5,
      FMT_RSV6 = 3'd6,
      FMT_RSV7 = 3'd7
   } sar_fmt_e;

   typedef struct packed {
      logic       legal;
      logic       rj;
      logic       i2s;
      logic [5:0] nbits;
      logic [5:0] min_half;
   } sar_cfg_t;

   function automatic sar_cfg_t sar_decode(input logic [2:0] code);
      sar_cfg_t c;
      c = '0;
      case (sar_fmt_e'(code))
         FMT_RJ16: c = '{1'b1, 1'b1, 1'b0, 6'd16, 6'd16};
         FMT_RJ20: c = '{1'b1, 1'b1, 1'b0, 6'd20, 6'd20};
         FMT_LJ:   c = '{1'b1, 1'b0, 1'b0, 6'd24, 6'd24};
         FMT_I2S:  c = '{1'b1, 1'b0, 1'b1, 6'd24, 6'd16};
         FMT_RJ24: c = '{1'b1, 1'b1, 1'b0, 6'd24, 6'd24};
         default:  c = '{1'b0, 1'b0, 1'b0, 6'd24, 6'd24};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) st[s] <= '0;
            end else begin
               st[0] <= d;
               for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sar_framer.sv
module sar_framer
   import sar_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_s,
   input  logic             fclk_s,
   input  logic             fmt_legal,
   input  logic             fmt_i2s,
   input  logic [5:0]       min_half,
   output logic             bit_en,
   output logic             boundary,
   output logic             ending_left,
   output logic             commit,
   output logic             emit,
   output logic [CNT_W-1:0] bit_pos,
   output logic             frame_err
);

   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] HALF_MAX = CNT_W'(SAR_MAX_HALF);

   logic             bclk_d;
   logic             fclk_d1;
   logic             eff_lr;
   logic             eff_prev;
   logic             synced;
   logic             left_seen;
   logic [1:0]       prime;
   logic [CNT_W-1:0] cnt;
   logic             half_ok;

   // I2S is handled as left-justified framing seen one bit clock late,
   // with the frame-clock polarity inverted.
   assign bit_en      = bclk_s & ~bclk_d;
   assign eff_lr      = fmt_i2s ? ~fclk_d1 : fclk_s;
   assign boundary    = bit_en & (prime == 2'd2) & (eff_lr != eff_prev);
   assign ending_left = eff_prev;
   assign bit_pos     = boundary ? '0 : cnt;
   assign half_ok     = (cnt >= CNT_W'(min_half)) && (cnt <= HALF_MAX);
   assign commit      = boundary & synced & fmt_legal;
   assign emit        = commit & ~ending_left & left_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d    <= 1'b0;
         fclk_d1   <= 1'b0;
         eff_prev  <= 1'b0;
         prime     <= 2'd0;
         cnt       <= '0;
         synced    <= 1'b0;
         left_seen <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         bclk_d <= bclk_s;
         if (bit_en) begin
            fclk_d1  <= fclk_s;
            eff_prev <= eff_lr;
            if (prime != 2'd2) prime <= prime + 2'd1;
            if (boundary)            cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
            else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         end
         if (boundary)              synced    <= 1'b1;
         if (commit & ending_left)  left_seen <= 1'b1;
         if (commit & ~half_ok)     frame_err <= 1'b1;
      end
   end

endmodule

// File: rtl/sar_lane.sv
module sar_lane
   import sar_pkg::*;
#(
   parameter int WORD_W = 24,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              boundary,
   input  logic              commit,
   input  logic              ending_left,
   input  logic [CNT_W-1:0]  bit_pos,
   input  logic              din,
   input  logic              fmt_rj,
   input  logic [5:0]        nbits,
   output logic [WORD_W-1:0] left_w,
   output logic [WORD_W-1:0] right_w
);

   logic [SAR_MAX_BITS-1:0] shift_q;
   logic [WORD_W-1:0]       asm_q;
   logic [WORD_W-1:0]       asm_next;
   logic [WORD_W-1:0]       rj_word;
   logic [WORD_W-1:0]       cap_word;

   always_comb begin
      rj_word  = WORD_W'(shift_q) << (WORD_W - SAR_MAX_BITS);
      rj_word  = rj_word << (6'(SAR_MAX_BITS) - nbits);
      cap_word = fmt_rj ? rj_word : asm_q;
      asm_next = boundary ? '0 : asm_q;
      for (int k = 0; k < SAR_MAX_BITS; k++) begin
         if (bit_pos == CNT_W'(k)) asm_next[WORD_W-1-k] = din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         asm_q   <= '0;
         left_w  <= '0;
         right_w <= '0;
      end else if (bit_en) begin
         shift_q <= {shift_q[SAR_MAX_BITS-2:0], din};
         asm_q   <= asm_next;
         if (commit) begin
            if (ending_left) left_w  <= cap_word;
            else             right_w <= cap_word;
         end
      end
   end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int LANES       = 3,
   parameter int WORD_W      = 24,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2:0]              fmt_sel,
   input  logic                    bclk_in,
   input  logic                    fclk_in,
   input  logic [LANES-1:0]        sdata_in,
   output logic [LANES*WORD_W-1:0] left_out,
   output logic [LANES*WORD_W-1:0] right_out,
   output logic                    frame_valid,
   output logic                    fmt_err,
   output logic                    frame_err
);

   localparam int SW = LANES + 2;

   if (LANES < 1) begin : g_chk_lanes
      $error("serial_audio_rx: LANES must be at least 1");
   end
   if (WORD_W < int'(SAR_MAX_BITS)) begin : g_chk_word
      $error("serial_audio_rx: WORD_W must hold a 24-bit word");
   end
   if (CNT_W < 6) begin : g_chk_cnt
      $error("serial_audio_rx: CNT_W must count past 32");
   end
   if (SYNC_STAGES < 0) begin : g_chk_sync
      $error("serial_audio_rx: SYNC_STAGES must not be negative");
   end

   logic [SW-1:0]    raw_in;
   logic [SW-1:0]    syn_in;
   logic             bclk_s;
   logic             fclk_s;
   logic [LANES-1:0] data_s;
   logic [2:0]       fmt_q;
   sar_cfg_t         cfg;
   logic             bit_en;
   logic             boundary;
   logic             ending_left;
   logic             commit;
   logic             emit;
   logic [CNT_W-1:0] bit_pos;

   assign raw_in = {bclk_in, fclk_in, sdata_in};

   sar_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign bclk_s = syn_in[SW-1];
   assign fclk_s = syn_in[SW-2];
   assign data_s = syn_in[LANES-1:0];

   // Format is followed while reset is held and frozen at release.
   always_ff @(posedge clk) begin
      if (!rst_n) fmt_q <= fmt_sel;
   end

   assign cfg = sar_decode(fmt_q);

   sar_framer #(.CNT_W(CNT_W)) u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk_s      (bclk_s),
      .fclk_s      (fclk_s),
      .fmt_legal   (cfg.legal),
      .fmt_i2s     (cfg.i2s),
      .min_half    (cfg.min_half),
      .bit_en      (bit_en),
      .boundary    (boundary),
      .ending_left (ending_left),
      .commit      (commit),
      .emit        (emit),
      .bit_pos     (bit_pos),
      .frame_err   (frame_err)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sar_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lane (
         .clk         (clk),
         .rst_n       (rst_n),
         .bit_en      (bit_en),
         .boundary    (boundary),
         .commit      (commit),
         .ending_left (ending_left),
         .bit_pos     (bit_pos),
         .din         (data_s[g]),
         .fmt_rj      (cfg.rj),
         .nbits       (cfg.nbits),
         .left_w      (left_out[g*WORD_W +: WORD_W]),
         .right_w     (right_out[g*WORD_W +: WORD_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_valid <= 1'b0;
         fmt_err     <= 1'b0;
      end else begin
         frame_valid <= emit;
         fmt_err     <= ~cfg.legal;
      end
   end

endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic frame_valid,
   input logic fmt_err,
   input logic frame_err
);

   assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   assert_valid_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(bit_en));

   assert_reserved_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> !frame_valid);

   assert_fmt_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |=> fmt_err);

   assert_frame_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   assert_reset_clear_R10: assert property (@(posedge clk)
      !rst_n |=> (!frame_valid && !frame_err && !fmt_err));

endmodule

bind serial_audio_rx sar_rx_chk u_sar_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_en      (bit_en),
   .frame_valid (frame_valid),
   .fmt_err     (fmt_err),
   .frame_err   (frame_err)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;

   localparam int LANES = 3;
   localparam int WW    = 24;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [2:0]          fmt_sel = 3'd2;
   logic                bclk_in = 1'b0;
   logic                fclk_in = 1'b0;
   logic [LANES-1:0]    sdata_in = '0;
   logic [LANES*WW-1:0] left_out;
   logic [LANES*WW-1:0] right_out;
   logic                frame_valid;
   logic                fmt_err;
   logic                frame_err;

   always #10 clk = ~clk;

   serial_audio_rx dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fmt_sel     (fmt_sel),
      .bclk_in     (bclk_in),
      .fclk_in     (fclk_in),
      .sdata_in    (sdata_in),
      .left_out    (left_out),
      .right_out   (right_out),
      .frame_valid (frame_valid),
      .fmt_err     (fmt_err),
      .frame_err   (frame_err)
   );

   int checks = 0;
   int errors = 0;
   int vcount = 0;
   logic [LANES*WW-1:0] cap_l = '0;
   logic [LANES*WW-1:0] cap_r = '0;
   logic [WW-1:0] wl [LANES];
   logic [WW-1:0] wr [LANES];

   always @(negedge clk) begin
      if (frame_valid === 1'b1) begin
         vcount++;
         cap_l = left_out;
         cap_r = right_out;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int rj_bits(input int mode);
      case (mode)
         0: return 16;
         1: return 20;
         4: return 24;
         default: return 0;
      endcase
   endfunction

   // Bit on the line at position idx of a half frame, left-justified view.
   function automatic logic word_bit(input int mode, input int half,
                                     input int idx, input logic [WW-1:0] w);
      int n;
      int pos;
      n = rj_bits(mode);
      if (n != 0) begin
         pos = idx - (half - n);
         if (pos >= 0) return w[WW-1-pos];
         return idx[0];
      end
      if (idx < 24) return w[WW-1-idx];
      return ~idx[0];
   endfunction

   task automatic apply_reset(input logic [2:0] mode);
      @(negedge clk);
      rst_n    = 1'b0;
      fmt_sel  = mode;
      bclk_in  = 1'b0;
      sdata_in = '0;
      fclk_in  = (mode == 3'd3) ? 1'b1 : 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      vcount = 0;
   endtask

   task automatic one_bit(input logic f, input logic [LANES-1:0] d);
      fclk_in  = f;
      sdata_in = d;
      repeat (4) @(negedge clk);
      bclk_in = 1'b1;
      repeat (4) @(negedge clk);
      bclk_in = 1'b0;
   endtask

   task automatic send_stream(input int mode, input int half, input int frames,
                              input bit i2s);
      logic [LANES-1:0] prev;
      logic [LANES-1:0] cur;
      int limit;
      prev  = '0;
      limit = frames * 2 * half + 2;
      for (int b = 0; b < limit; b++) begin
         int hb;
         int h;
         int i;
         logic left;
         hb   = b % (2 * half);
         h    = hb / half;
         i    = hb % half;
         left = (h == 0);
         for (int l = 0; l < LANES; l++)
            cur[l] = word_bit(mode, half, i, left ? wl[l] : wr[l]);
         one_bit(i2s ? ~left : left, i2s ? prev : cur);
         prev = cur;
      end
      repeat (10) @(negedge clk);
   endtask

   task automatic check_words(input string req, input int mode, input int half);
      logic [WW-1:0] mask;
      int n;
      n = rj_bits(mode);
      if (n != 0)         mask = ~24'h0 << (24 - n);
      else if (half < 24) mask = ~24'h0 << (24 - half);
      else                mask = ~24'h0;
      for (int l = 0; l < LANES; l++) begin
         check(req, $sformatf("lane%0d left", l),  32'(cap_l[l*WW +: WW]), 32'(wl[l] & mask));
         check(req, $sformatf("lane%0d right", l), 32'(cap_r[l*WW +: WW]), 32'(wr[l] & mask));
      end
   endtask

   task automatic set_words(input logic [WW-1:0] base);
      for (int l = 0; l < LANES; l++) begin
         wl[l] = base ^ (24'h13579B * (l + 1));
         wr[l] = ~base ^ (24'h2468AC * (l + 3));
      end
   endtask

   task automatic t_reset;
      apply_reset(3'd2);
      check("R10", "left_out",    32'(left_out[31:0]), 32'h0);
      check("R10", "right_out",   32'(right_out[31:0]), 32'h0);
      check("R10", "frame_valid", 32'(frame_valid), 32'h0);
      check("R10", "fmt_err",     32'(fmt_err), 32'h0);
      check("R10", "frame_err",   32'(frame_err), 32'h0);
   endtask

   task automatic t_left_justified;
      apply_reset(3'd2);
      set_words(24'h80_0F1E);
      send_stream(2, 32, 4, 1'b0);
      check("R5", "valid count lj", 32'(vcount), 32'd3);
      check_words("R2_R1_R6", 2, 32);
      check("R9", "no frame_err lj", 32'(frame_err), 32'h0);
   endtask

   task automatic t_i2s;
      apply_reset(3'd3);
      set_words(24'h7F_E001);
      send_stream(3, 32, 4, 1'b1);
      check("R5", "valid count i2s", 32'(vcount), 32'd3);
      check_words("R3", 3, 32);
      apply_reset(3'd3);
      set_words(24'hC3_A55A);
      send_stream(3, 16, 4, 1'b1);
      check_words("R3_R11 i2s16", 3, 16);
      check("R9", "i2s16 legal", 32'(frame_err), 32'h0);
   endtask

   task automatic t_right_justified;
      apply_reset(3'd0);
      set_words(24'h96_3C11);
      send_stream(0, 32, 3, 1'b0);
      check_words("R4_R11 rj16 pad", 0, 32);
      check("R9", "rj16 at 32 legal", 32'(frame_err), 32'h0);
      apply_reset(3'd0);
      set_words(24'h1E_E1F0);
      send_stream(0, 16, 3, 1'b0);
      check_words("R4 rj16", 0, 16);
      apply_reset(3'd1);
      set_words(24'hA0_0005);
      send_stream(1, 20, 3, 1'b0);
      check_words("R4_R11 rj20", 1, 20);
      check("R5", "valid count rj20", 32'(vcount), 32'd2);
      apply_reset(3'd4);
      set_words(24'h5A_F00D);
      send_stream(4, 24, 3, 1'b0);
      check_words("R4 rj24", 4, 24);
      check("R9", "rj24 legal", 32'(frame_err), 32'h0);
   endtask

   task automatic t_reserved;
      apply_reset(3'd6);
      set_words(24'h12_3456);
      send_stream(2, 32, 3, 1'b0);
      check("R8", "fmt_err", 32'(fmt_err), 32'h1);
      check("R8", "no valid", 32'(vcount), 32'd0);
   endtask

   task automatic t_latch;
      apply_reset(3'd2);
      fmt_sel = 3'd5;
      set_words(24'h0F_F0AA);
      send_stream(2, 32, 3, 1'b0);
      check("R7", "fmt_err after change", 32'(fmt_err), 32'h0);
      check("R7", "valid count", 32'(vcount), 32'd2);
      check_words("R7", 2, 32);
   endtask

   task automatic t_frame_err;
      apply_reset(3'd2);
      set_words(24'h44_8821);
      send_stream(2, 20, 3, 1'b0);
      check("R9", "lj half 20 short", 32'(frame_err), 32'h1);
      apply_reset(3'd2);
      check("R10", "frame_err cleared", 32'(frame_err), 32'h0);
      apply_reset(3'd3);
      send_stream(3, 33, 3, 1'b1);
      check("R9", "i2s half 33 long", 32'(frame_err), 32'h1);
      set_words(24'hE7_0C3F);
      send_stream(3, 32, 4, 1'b1);
      check("R9", "sticky after good frames", 32'(frame_err), 32'h1);
      check_words("R9 data after error", 3, 32);
   endtask

   initial begin
      t_reset();
      t_left_justified();
      t_i2s();
      t_right_justified();
      t_reserved();
      t_latch();
      t_frame_err();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule